// File: doc/BRIEF.md
# Glitch-Filtered Reset Generator

This block produces the single active-low reset used inside the chip. It combines two sources: a power-on pulse timed internally from the moment the power-good indication rises, and an external active-low reset pin. The external pin goes through a two-flop synchroniser. It only counts as a request once it has been seen low for more consecutive clock samples than fit in a configurable glitch window. Short single-event transients on the pin are therefore dropped.

When an external request qualifies, the internal reset is held for a minimum number of cycles after the pin is released. Any low sample seen during that hold restarts the hold count. A low power-good clears everything at once, without waiting for a clock edge. Every release of the internal reset comes from a flop on the local clock, so the output has no glitches. A separate flag shows that the power-on pulse is still running.

Top module: `glitch_rst_gen`

## Requirements
- R1: While `pwr_good` is 0, `rst_int_n` is 0 and `por_busy` is 1. Both take these values immediately when `pwr_good` falls, with no clock edge needed.
- R2: Let P = POR_US × CLK_MHZ cycles (1 ms by default). Count rising clock edges from the first one after `pwr_good` rises. `por_busy` stays 1 through edge P+1 and falls on edge P+2. `rst_int_n` rises on edge P+3, and it changes only on clock edges.
- R3: Once `por_busy` has fallen, it stays 0 for as long as `pwr_good` stays 1.
- R4: Let Q = ceil(GLITCH_NS × CLK_MHZ / 1000). A low pulse on `ext_rst_n_raw` that is sampled low on at most Q consecutive edges leaves `rst_int_n` at 1.
- R5: Suppose `ext_rst_n_raw` is sampled low on edges 1..W, with W ≥ Q+1. Then `rst_int_n` falls on edge Q+4.
- R6: After a qualified request whose last low sample is edge E, `rst_int_n` stays 0 through edge E+HOLD_CYCLES+2 and rises on edge E+HOLD_CYCLES+3.
- R7: A request that stays low keeps `rst_int_n` at 0 for the whole time it is low.
- R8: Any low sample of `ext_rst_n_raw` during the hold restarts the hold count, even one shorter than the glitch window. The release then follows R6, with E taken as the last low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, used as the filter sampling clock |
| ext_rst_n_raw | input | 1 | Raw external reset pin, active low, asynchronous |
| pwr_good | input | 1 | Power-good indication; 0 resets everything asynchronously |
| rst_int_n | output | 1 | Filtered internal reset, active low, released from a flop |
| por_busy | output | 1 | 1 while the power-on pulse is still running |

## Verification
The bench goes after the edge of the glitch window: pulses of exactly Q samples and of Q+1 samples. A counter off by one would either let a transient through or drop a real request. It measures the power-on pulse to the exact edge, which exposes a timer that releases early or late. It also checks the hold both after a plain release and after a sub-window glitch that lands inside the hold. A design that fails to restart the count would release at the first deadline, and one that releases too early would cut the hold short. Finally, power-good is dropped between clock edges, and the bench checks that the reset asserts before any clock edge follows.

// File: rtl/rg_pkg.sv
package rg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Cycles needed to cover a window in ns, rounded up.
  function automatic int unsigned ns_to_cycles_ceil(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Bits needed to hold the value maxval.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/rg_sync2.sv
module rg_sync2 (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rg_por_timer.sv
module rg_por_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic arst_n,
  output logic busy
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CW = rg_pkg::cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign busy = ~done;
endmodule

// File: rtl/rg_glitch_qual.sv
module rg_glitch_qual #(
  parameter int unsigned QUAL = 2,
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic active
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned RW = rg_pkg::cnt_width(QUAL);
  localparam int unsigned HW = rg_pkg::cnt_width(HOLD);
  localparam logic [RW-1:0] RUN_MAX = RW'(QUAL);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD);

  logic [RW-1:0] run;
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run    <= '0;
      hold   <= '0;
      active <= 1'b0;
    end else begin
      // consecutive-sample counter, saturating at the window length
      if (!req)               run <= '0;
      else if (run != RUN_MAX) run <= run + 1'b1;

      if (req) begin
        // qualify after QUAL+1 samples; any sample while active reloads hold
        if (active || run == RUN_MAX) begin
          active <= 1'b1;
          hold   <= HOLD_LD;
        end
      end else if (active) begin
        if (hold <= HW'(1)) active <= 1'b0;
        else                hold   <= hold - 1'b1;
      end
    end
  end
endmodule

// File: rtl/glitch_rst_gen.sv
module glitch_rst_gen #(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned POR_US      = 1000,
  parameter int unsigned GLITCH_NS   = 8,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic ext_rst_n_raw,
  input  logic pwr_good,
  output logic rst_int_n,
  output logic por_busy
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned POR_CYC  = POR_US * CLK_MHZ;
  localparam int unsigned QUAL_CYC = rg_pkg::ns_to_cycles_ceil(GLITCH_NS, CLK_MHZ);

  logic pok;
  logic ext_req;
  logic ext_act;
  logic busy;
  logic rst_q;

  // Power-good: asynchronous assertion, release synchronised to clk
  rg_sync2 u_pok_sync (
    .clk    (clk),
    .arst_n (pwr_good),
    .d      (1'b1),
    .q      (pok)
  );

  rg_sync2 u_ext_sync (
    .clk    (clk),
    .arst_n (pok),
    .d      (~ext_rst_n_raw),
    .q      (ext_req)
  );

  rg_por_timer #(.CYCLES(POR_CYC)) u_por (
    .clk    (clk),
    .arst_n (pok),
    .busy   (busy)
  );

  rg_glitch_qual #(.QUAL(QUAL_CYC), .HOLD(HOLD_CYCLES)) u_qual (
    .clk    (clk),
    .arst_n (pok),
    .req    (ext_req),
    .active (ext_act)
  );

  // Output flop: glitch-free, released only on a clock edge
  always_ff @(posedge clk or negedge pok) begin
    if (!pok) rst_q <= 1'b0;
    else      rst_q <= ~(busy | ext_act);
  end

  assign rst_int_n = rst_q;
  assign por_busy  = busy;
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int unsigned QUAL = 2,
  parameter int unsigned HOLD = 16
) (
  input logic clk,
  input logic pwr_good,
  input logic ext_rst_n_raw,
  input logic rst_int_n,
  input logic por_busy
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned LMAX = QUAL + 4;
  localparam int unsigned LW   = rg_pkg::cnt_width(LMAX);
  localparam int unsigned HW   = rg_pkg::cnt_width(HOLD);

  logic [LW-1:0] low_run;
  logic [HW-1:0] high_run;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      low_run  <= '0;
      high_run <= '0;
    end else if (!ext_rst_n_raw) begin
      high_run <= '0;
      if (low_run != LW'(LMAX)) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
      if (high_run != HW'(HOLD)) high_run <= high_run + 1'b1;
    end
  end

  // R1: power loss forces reset with no clock edge needed
  always @(negedge clk) begin
    if (pwr_good === 1'b0)
      a_r1_async_assert: assert (rst_int_n === 1'b0 && por_busy === 1'b1);
  end

  // R2
  a_r2_busy_masks_out: assert property (@(posedge clk) disable iff (!pwr_good)
    por_busy |-> !rst_int_n);

  // R3
  a_r3_por_once: assert property (@(posedge clk) disable iff (!pwr_good)
    !por_busy |=> !por_busy);

  // R7: a long low request must show on the output
  a_r7_long_low: assert property (@(posedge clk) disable iff (!pwr_good)
    (low_run >= LW'(LMAX)) |-> !rst_int_n);

  // R6: release after an external request needs HOLD clean samples
  a_r6_hold_min: assert property (@(posedge clk) disable iff (!pwr_good)
    ($rose(rst_int_n) && !$past(por_busy, 2)) |-> (high_run >= HW'(HOLD)));
endmodule

bind glitch_rst_gen rg_checker #(.QUAL(QUAL_CYC), .HOLD(HOLD_CYCLES)) u_chk (
  .clk           (clk),
  .pwr_good      (pwr_good),
  .ext_rst_n_raw (ext_rst_n_raw),
  .rst_int_n     (rst_int_n),
  .por_busy      (por_busy)
);

// File: tb/glitch_rst_gen_tb.sv
module glitch_rst_gen_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CLK_MHZ   = 100;
  localparam int unsigned POR_US    = 10;
  localparam int unsigned GLITCH_NS = 40;
  localparam int unsigned HOLD      = 16;
  localparam int unsigned P = POR_US * CLK_MHZ;
  localparam int unsigned Q = (GLITCH_NS * CLK_MHZ + 999) / 1000;

  localparam int NV = 6;
  localparam int unsigned VW [NV] = '{1, 3, 4, 5, 9, 20};
  localparam bit          VQ [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic ext_rst_n_raw = 1'b1;
  logic pwr_good = 1'b1;
  logic rst_int_n;
  logic por_busy;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;   // 100 MHz

  glitch_rst_gen #(
    .CLK_MHZ(CLK_MHZ), .POR_US(POR_US), .GLITCH_NS(GLITCH_NS), .HOLD_CYCLES(HOLD)
  ) u_dut (
    .clk           (clk),
    .ext_rst_n_raw (ext_rst_n_raw),
    .pwr_good      (pwr_good),
    .rst_int_n     (rst_int_n),
    .por_busy      (por_busy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Raise pwr_good at a negedge and check the power-on pulse timing
  task automatic power_up();
    pwr_good = 1'b1;
    for (int k = 1; k <= int'(P) + 3; k++) begin
      step();
      if (k == int'(P) + 1) begin
        chk("R2 busy before end", por_busy, 1'b1);
        chk("R2 rst before end", rst_int_n, 1'b0);
      end
      if (k == int'(P) + 2) begin
        chk("R2 busy falls", por_busy, 1'b0);
        chk("R2 rst still low", rst_int_n, 1'b0);
      end
      if (k == int'(P) + 3) chk("R2 rst rises", rst_int_n, 1'b1);
    end
  endtask

  initial begin
    #1 pwr_good = 1'b0;
    @(negedge clk);
    chk("R1 reset state rst", rst_int_n, 1'b0);
    chk("R1 reset state busy", por_busy, 1'b1);
    step();
    power_up();
    repeat (10) step();

    // Table of pulse widths: R4 (ignored) and R5/R6 (qualified)
    for (int v = 0; v < NV; v++) begin
      ext_rst_n_raw = 1'b0;
      for (int k = 1; k <= int'(VW[v] + HOLD) + 8; k++) begin
        step();
        if (k == int'(VW[v])) ext_rst_n_raw = 1'b1;
        if (!VQ[v])
          chk("R4 short pulse ignored", rst_int_n, 1'b1);
        else if (k <= int'(VW[v]) + int'(HOLD))
          chk("R5 qualified assert", rst_int_n,
              (k >= int'(Q) + 4) ? 1'b0 : 1'b1);
        else
          chk("R6 hold release", rst_int_n,
              (k <= int'(VW[v] + HOLD) + 2) ? 1'b0 : 1'b1);
      end
      repeat (5) step();
    end

    // R7: long held request
    ext_rst_n_raw = 1'b0;
    for (int k = 1; k <= 150 + int'(HOLD) + 6; k++) begin
      step();
      if (k == 150) ext_rst_n_raw = 1'b1;
      if (k == int'(Q) + 4) chk("R7 low at qualify", rst_int_n, 1'b0);
      if (k == 149) chk("R7 low while held", rst_int_n, 1'b0);
      if (k == 150 + int'(HOLD) + 2) chk("R6 low at last hold edge", rst_int_n, 1'b0);
      if (k == 150 + int'(HOLD) + 3) chk("R6 rise after long hold", rst_int_n, 1'b1);
    end
    repeat (5) step();

    // R8: short glitch during hold restarts the count (last low edge 12)
    ext_rst_n_raw = 1'b0;
    for (int k = 1; k <= 12 + int'(HOLD) + 6; k++) begin
      step();
      if (k == 6)  ext_rst_n_raw = 1'b1;
      if (k == 10) ext_rst_n_raw = 1'b0;
      if (k == 12) ext_rst_n_raw = 1'b1;
      if (k == 6 + int'(HOLD) + 3) chk("R8 hold restarted", rst_int_n, 1'b0);
      if (k == 12 + int'(HOLD) + 2) chk("R8 low at new deadline", rst_int_n, 1'b0);
      if (k == 12 + int'(HOLD) + 3) chk("R8 rise at new deadline", rst_int_n, 1'b1);
    end

    // R3: power-on flag stays down
    repeat (20) step();
    chk("R3 busy stays low", por_busy, 1'b0);

    // R1: power loss between clock edges
    #2 pwr_good = 1'b0;
    #1;
    chk("R1 async rst", rst_int_n, 1'b0);
    chk("R1 async busy", por_busy, 1'b1);
    @(negedge clk);
    step();
    power_up();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200_000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule